// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit sits next to an SD/MMC host engine and turns its one-cycle event pulses into sticky status flags that software can read and acknowledge. It covers command completion, response and data timeouts, the three CRC error kinds, single-block and multi-block completion, auto-stop completion and the SDIO card interrupt. Two card-detect pins and a write-protect pin are synchronised, and their levels are shown next to the event flags.

Software reaches the unit through a small byte-wide register port. It clears a flag by writing 1 to that bit. Per-bit enables and a master enable combine the flags into one level-sensitive interrupt line. A control byte chooses which pin acts as card detect and what polarity it has. Any edge on the chosen pin latches both a card-change event and an insertion event. A soft-reset pulse drops every latched event and leaves the configuration as it was.

Top module: `sdh_irq_status`

Register offsets: 0 is the primary status byte, 1 the secondary status byte, 2 the primary enable byte, 3 the secondary enable byte and 4 the control byte. Control byte bits: bit7 is the master enable, bit6 selects DAT3 as the detect source, bit5 selects the GPI pin as the detect source (and takes priority over bit6), bit4 makes detect active-high, and bit3 requests abort on CRC error. Bits 2..0 of the control byte read 0.

## Requirements
- R1: After rst_n the sticky bits of both status bytes, both enable bytes and the control byte read 0, and irq_o is 0.
- R2: A pulse on core_evt_i[k] sets bit k of the secondary status byte (bit0 SDIO interrupt, bit1 command done, bit2 response timeout, bit3 auto-stop done, bit4 data timeout, bit5 response CRC error, bit6 read CRC error, bit7 write CRC error). mblk_done_i sets primary bit4 and blk_done_i sets primary bit5. All of these flags are readable after the next clock edge.
- R3: Writing a status byte clears each sticky bit written as 1 and leaves each bit written as 0 unchanged, so 0xFF clears the whole byte.
- R4: When an event pulse and a write-1 clear of the same bit fall in one cycle, the bit ends up set.
- R5: Primary status bits 3..1 show the live levels (bit3 GPI presence, bit2 DAT3 presence, bit1 write-protect pin) and bit0 reads 0. Writes do not change any of these bits.
- R6: Only primary enable bits 7..4 and secondary enable bits 7..1 can be written. The other enable bits read 0, so the SDIO flag (secondary bit0) never raises irq_o.
- R7: irq_o equals control bit7 ANDed with the OR of (status AND enable) over both bytes.
- R8: Presence bits are the pin level after a two-flop synchroniser. That level is inverted when control bit4 is 0 (active-low) and used as is when bit4 is 1.
- R9: An edge on the selected detect pin sets primary bits 6 and 7 on the third clock edge after the pin changes. An edge on an unselected pin sets neither bit.
- R10: A soft_rst_i pulse clears every sticky status bit, even against a same-cycle event, and keeps the enables and the control byte.
- R11: crc_abort_o follows control bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Clears all latched events |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| core_evt_i | input | 8 | Host engine event pulses, secondary byte order |
| blk_done_i | input | 1 | Single-block done pulse |
| mblk_done_i | input | 1 | Multi-block done pulse |
| cd_gpi_i | input | 1 | GPI card-detect pin (asynchronous) |
| cd_dat3_i | input | 1 | DAT3 card-detect pin (asynchronous) |
| wp_i | input | 1 | Write-protect pin (asynchronous) |
| irq_o | output | 1 | Level interrupt |
| crc_abort_o | output | 1 | Abort-on-CRC-error request |

## Verification
A status flag that sticks or is lost shows up on the read port after one clock, and on irq_o in the same cycle when that flag is enabled. A fault in the card-detect path, such as a wrong stage count or a wrong source select, shows up as an event that appears one cycle early or late, or at the wrong pin, against an exact third-edge expectation. A clear that wins over a simultaneous event, or a soft reset that also wipes the enables, is exposed by reading back right after the colliding cycle.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int AW     = 3;

  localparam logic [AW-1:0] A_STAT0 = 3'd0;
  localparam logic [AW-1:0] A_STAT1 = 3'd1;
  localparam logic [AW-1:0] A_MASK0 = 3'd2;
  localparam logic [AW-1:0] A_MASK1 = 3'd3;
  localparam logic [AW-1:0] A_CTRL  = 3'd4;

  localparam logic [BYTE_W-1:0] STAT0_STICKY = 8'hF0;
  localparam logic [BYTE_W-1:0] STAT1_STICKY = 8'hFF;
  localparam logic [BYTE_W-1:0] MASK0_IMPL   = 8'hF0;
  localparam logic [BYTE_W-1:0] MASK1_IMPL   = 8'hFE;
  localparam logic [BYTE_W-1:0] CTRL_IMPL    = 8'hF8;

  localparam int CB_MASTER = 7;
  localparam int CB_DAT3   = 6;
  localparam int CB_GPI    = 5;
  localparam int CB_POLHI  = 4;
  localparam int CB_CRCABT = 3;

  // Next value of a write-1-to-clear byte; a set in the same cycle wins.
  function automatic logic [BYTE_W-1:0] w1c_next(
    input logic [BYTE_W-1:0] cur,
    input logic [BYTE_W-1:0] set,
    input logic              wr,
    input logic [BYTE_W-1:0] wd
  );
    logic [BYTE_W-1:0] clr;
    clr = wr ? wd : '0;
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(
    input logic              master,
    input logic [BYTE_W-1:0] s0,
    input logic [BYTE_W-1:0] m0,
    input logic [BYTE_W-1:0] s1,
    input logic [BYTE_W-1:0] m1
  );
    return master & ((|(s0 & m0)) | (|(s1 & m1)));
  endfunction
endpackage

// File: rtl/sdh_cd_sync.sv
module sdh_cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], pin_i};
  end

  assign lvl_o = sh_q[STAGES-1];
endmodule

// File: rtl/sdh_sticky_byte.sv
module sdh_sticky_byte
  import sdh_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr_i,
  input  logic [BYTE_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] q_o
);
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    nxt = soft_clr_i ? '0 : (w1c_next(q_o, set_i, wr_i, wdata_i) & IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_chk
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[i] && !soft_clr_i) |=> q_o[i]); // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[i] && !set_i[i] && !soft_clr_i) |=> !q_o[i]); // R3
      AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[i] && !(wr_i && wdata_i[i]) && !soft_clr_i) |=> (q_o[i] == $past(q_o[i]))); // R3
      AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr_i |=> !q_o[i]); // R10
    end
  end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [BYTE_W-1:0] core_evt_i,
  input  logic              blk_done_i,
  input  logic              mblk_done_i,
  input  logic              cd_gpi_i,
  input  logic              cd_dat3_i,
  input  logic              wp_i,
  output logic              irq_o,
  output logic              crc_abort_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   pin_raw, pin_lvl;
  logic [1:0]        cd_prev_q;
  logic [BYTE_W-1:0] mask0_q, mask1_q, ctrl_q;
  logic [BYTE_W-1:0] st0_sticky, st1_q, st0_view, st0_set;
  logic              gpi_edge, dat3_edge, cd_edge;
  logic              gpi_present, dat3_present;
  logic              wr_st0, wr_st1;

  assign pin_raw = {wp_i, cd_dat3_i, cd_gpi_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    sdh_cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_raw[g]),
      .lvl_o (pin_lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cd_prev_q <= '0;
    else        cd_prev_q <= pin_lvl[1:0];
  end

  assign gpi_edge     = pin_lvl[0] ^ cd_prev_q[0];
  assign dat3_edge    = pin_lvl[1] ^ cd_prev_q[1];
  assign cd_edge      = ctrl_q[CB_GPI] ? gpi_edge : (ctrl_q[CB_DAT3] & dat3_edge);
  assign gpi_present  = ctrl_q[CB_POLHI] ? pin_lvl[0] : ~pin_lvl[0];
  assign dat3_present = ctrl_q[CB_POLHI] ? pin_lvl[1] : ~pin_lvl[1];

  assign wr_st0  = reg_wr_i && (reg_addr_i == A_STAT0);
  assign wr_st1  = reg_wr_i && (reg_addr_i == A_STAT1);
  assign st0_set = {cd_edge, cd_edge, blk_done_i, mblk_done_i, 4'b0000};

  sdh_sticky_byte #(.IMPL(STAT0_STICKY)) u_st0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr_i (soft_rst_i),
    .set_i      (st0_set),
    .wr_i       (wr_st0),
    .wdata_i    (reg_wdata_i),
    .q_o        (st0_sticky)
  );

  sdh_sticky_byte #(.IMPL(STAT1_STICKY)) u_st1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr_i (soft_rst_i),
    .set_i      (core_evt_i),
    .wr_i       (wr_st1),
    .wdata_i    (reg_wdata_i),
    .q_o        (st1_q)
  );

  assign st0_view = {st0_sticky[7:4], gpi_present, dat3_present, pin_lvl[2], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask0_q <= '0;
      mask1_q <= '0;
      ctrl_q  <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_MASK0) mask0_q <= reg_wdata_i & MASK0_IMPL;
      if (reg_addr_i == A_MASK1) mask1_q <= reg_wdata_i & MASK1_IMPL;
      if (reg_addr_i == A_CTRL)  ctrl_q  <= reg_wdata_i & CTRL_IMPL;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT0: reg_rdata_o = st0_view;
      A_STAT1: reg_rdata_o = st1_q;
      A_MASK0: reg_rdata_o = mask0_q;
      A_MASK1: reg_rdata_o = mask1_q;
      A_CTRL:  reg_rdata_o = ctrl_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = irq_level(ctrl_q[CB_MASTER], st0_view, mask0_q, st1_q, mask1_q);
  assign crc_abort_o = ctrl_q[CB_CRCABT];

  AST_CD_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_edge && !soft_rst_i) |=> (st0_sticky[6] && st0_sticky[7])); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl_q[CB_MASTER] && ((|(st1_q[7:1] & mask1_q[7:1])) || (|(st0_sticky & mask0_q))))); // R7
  AST_SDIO_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st1_q == 8'h01 && st0_sticky == 8'h00) |-> !irq_o); // R6
  AST_MASK_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0_q[3:0] == 4'h0) && !mask1_q[0]); // R6
endmodule

// File: tb/sdh_irq_status_bench.sv
module sdh_irq_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [2:0] reg_addr_i = 3'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic [7:0] core_evt_i = 8'h00;
  logic       blk_done_i = 1'b0;
  logic       mblk_done_i = 1'b0;
  logic       cd_gpi_i = 1'b1;
  logic       cd_dat3_i = 1'b1;
  logic       wp_i = 1'b0;
  logic       irq_o;
  logic       crc_abort_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdh_irq_status u_sdh_irq_status (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .core_evt_i(core_evt_i),
    .blk_done_i(blk_done_i), .mblk_done_i(mblk_done_i),
    .cd_gpi_i(cd_gpi_i), .cd_dat3_i(cd_dat3_i), .wp_i(wp_i),
    .irq_o(irq_o), .crc_abort_o(crc_abort_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R1 stat0 sticky", v & 8'hF0, 8'h00);
    rd(3'd1, v); chk("R1 stat1", v, 8'h00);
    rd(3'd2, v); chk("R1 mask0", v, 8'h00);
    rd(3'd3, v); chk("R1 mask1", v, 8'h00);
    rd(3'd4, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    @(negedge clk); core_evt_i = 8'hA5;
    @(negedge clk); core_evt_i = 8'h00;
    rd(3'd1, v); chk("R2 stat1 pattern A5", v, 8'hA5);
    @(negedge clk); core_evt_i = 8'h5A; blk_done_i = 1'b1;
    @(negedge clk); core_evt_i = 8'h00; blk_done_i = 1'b0;
    rd(3'd1, v); chk("R2 stat1 accumulates", v, 8'hFF);
    rd(3'd0, v); chk("R2 blk done bit5", v & 8'hF0, 8'h20);
    @(negedge clk); mblk_done_i = 1'b1;
    @(negedge clk); mblk_done_i = 1'b0;
    rd(3'd0, v); chk("R2 mblk done bit4", v & 8'hF0, 8'h30);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    wr(3'd1, 8'h0F);
    rd(3'd1, v); chk("R3 partial clear", v, 8'hF0);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R3 zero write keeps", v, 8'hF0);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R3 full clear", v, 8'h00);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R3 stat0 clear", v & 8'hF0, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 8'hFF; core_evt_i = 8'h04;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00; core_evt_i = 8'h00;
    rd(3'd1, v); chk("R4 event beats clear", v, 8'h04);
    wr(3'd1, 8'hFF);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    @(negedge clk); wp_i = 1'b1;
    cycles(3);
    rd(3'd0, v); chk("R5 wp level and presence", v & 8'h0F, 8'h02);
    wr(3'd0, 8'h0F);
    rd(3'd0, v); chk("R5 write ignored", v & 8'h0F, 8'h02);
    @(negedge clk); wp_i = 1'b0;
    cycles(3);
    rd(3'd0, v); chk("R5 wp follows pin", v & 8'h0F, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R6 mask0 writable bits", v, 8'hF0);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R6 mask1 writable bits", v, 8'hFE);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R11 ctrl writable bits", v, 8'hF8);
    chk("R11 crc abort set", {7'd0, crc_abort_o}, 8'h01);
    wr(3'd4, 8'h80);
    chk("R11 crc abort clear", {7'd0, crc_abort_o}, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); core_evt_i = 8'h01;
    @(negedge clk); core_evt_i = 8'h00;
    chk("R6 SDIO flag never interrupts", {7'd0, irq_o}, 8'h00);
    @(negedge clk); core_evt_i = 8'h04;
    @(negedge clk); core_evt_i = 8'h00;
    chk("R7 irq on enabled flag", {7'd0, irq_o}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R7 master off", {7'd0, irq_o}, 8'h00);
    wr(3'd4, 8'h80);
    chk("R7 master on", {7'd0, irq_o}, 8'h01);
    wr(3'd3, 8'hFA);
    chk("R7 enable bit off", {7'd0, irq_o}, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hFE);
    @(negedge clk); blk_done_i = 1'b1;
    @(negedge clk); blk_done_i = 1'b0;
    chk("R7 primary flag irq", {7'd0, irq_o}, 8'h01);
    wr(3'd0, 8'h20);
    chk("R7 irq drops after clear", {7'd0, irq_o}, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_cd();
    logic [7:0] v;
    rd(3'd0, v); chk("R8 no card active-low", v & 8'h0C, 8'h00);
    wr(3'd4, 8'h20);
    @(negedge clk); cd_dat3_i = 1'b0;
    cycles(4);
    rd(3'd0, v); chk("R9 unselected edge ignored", v & 8'hC0, 8'h00);
    chk("R8 dat3 present", v & 8'h0C, 8'h04);
    @(negedge clk); cd_gpi_i = 1'b0;
    cycles(2);
    rd(3'd0, v); chk("R8 gpi level after two flops", v & 8'h0C, 8'h0C);
    chk("R9 no event before third edge", v & 8'hC0, 8'h00);
    cycles(1);
    rd(3'd0, v); chk("R9 event on third edge", v & 8'hC0, 8'hC0);
    wr(3'd4, 8'h30);
    rd(3'd0, v); chk("R8 active-high polarity", v & 8'h0C, 8'h00);
    wr(3'd0, 8'hC0);
    wr(3'd4, 8'h40);
    @(negedge clk); cd_dat3_i = 1'b1;
    cycles(3);
    rd(3'd0, v); chk("R9 dat3 source edge", v & 8'hC0, 8'hC0);
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(3'd2, 8'hB0);
    @(negedge clk); core_evt_i = 8'hF0; mblk_done_i = 1'b1;
    @(negedge clk); core_evt_i = 8'h00; mblk_done_i = 1'b0;
    @(negedge clk); soft_rst_i = 1'b1; core_evt_i = 8'h02;
    @(negedge clk); soft_rst_i = 1'b0; core_evt_i = 8'h00;
    rd(3'd1, v); chk("R10 stat1 cleared", v, 8'h00);
    rd(3'd0, v); chk("R10 stat0 cleared", v & 8'hF0, 8'h00);
    rd(3'd2, v); chk("R10 mask kept", v, 8'hB0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    cycles(4);
    t_events();
    t_w1c();
    t_collide();
    t_readonly();
    t_masks();
    t_irq();
    t_cd();
    t_soft();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule